// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block collects interrupt events from three sources (transmit, receive and miscellaneous) into three 32-bit cause groups. Each group latches event pulses and has a per-bit mask. It also has a per-bit clear-mode setting that makes each bit either clear-on-read or write-one-to-clear. Software can raise any cause bit itself.

A three-bit summary register carries one bit per group. A group's bit sets while that group has a pending bit that is not masked. The summary register clears when it is read, and it has its own software mask. The masked summary drives a single registered interrupt line. A host reaches every register through a simple single-cycle register bus. Read data appears on the cycle after the request.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every cause bit is 0, every group mask and the summary mask read 0xFFFFFFFF, every clear-mode register reads 0 (all bits write-one-to-clear), and irq_o is 0.
- R2: A 1 on any bit of an event input for one cycle sets the matching cause bit, and the bit stays set until it is cleared.
- R3: Writing to the cause register (register 0) clears each bit written as 1 whose clear-mode bit is 0. Bits written as 0 are unchanged. Bits whose clear-mode bit is 1 ignore the write.
- R4: Reading the cause register returns the latched cause and then clears exactly the bits whose clear-mode bit (register 6) is 1. With MISC mode 0xF7FFFFFF, bit 27 survives the read. Without a clear or a bus access, no cause bit drops.
- R5: An event that hits a bit in the same cycle as a clear of that bit, by write or by read, leaves the bit set.
- R6: Writing register 2 sets the mask bits written as 1, and writing register 3 clears them. Bits written as 0 keep their value. Register 4 reads the current mask.
- R7: Register 5 reads the cause ANDed with the inverted mask, and reading it clears nothing.
- R8: Writing register 1 sets every cause bit written as 1.
- R9: Summary bits are TX at bit 0, RX at bit 1 and MISC at bit 2. A summary bit sets whenever its group has a cause bit that is set and unmasked. Reading the summary (group 3, register 0) returns it and clears it, except for bits whose group is still pending.
- R10: The summary mask is group 3, register 1 (read/write). irq_o is registered: one cycle after the summary state, it is high when any summary bit is set whose summary-mask bit is 0.
- R11: The word address is {group[5:3], register[2:0]}, with group 0 = TX, 1 = RX, 2 = MISC and 3 = summary. A read returns its data on rdata_o in the cycle after the request. Undefined addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word address {group, register} |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| tx_evt_i | input | 32 | TX event pulses, one per cause bit |
| rx_evt_i | input | 32 | RX event pulses, one per cause bit |
| misc_evt_i | input | 32 | MISC event pulses, one per cause bit |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets mixed clear modes. It checks that a clear-on-read bit vanishes after one read while a write-one-to-clear neighbour survives it, and that bit 27 of MISC survives a read under the mixed setting. A design that applied one mode to the whole register would fail those reads.

It also drives an event and a clear into the same bit in the same cycle; a design that gave the clear priority would lose the event. The summary is checked to stay latched after its group is masked or cleared, and to drop only on the read after that. irq_o is checked to follow the summary mask with one cycle of delay, so an unregistered or inverted mask would be caught.

// File: rtl/icb_pkg.sv
package icb_pkg;
  localparam int GRP_W  = 3;
  localparam int REG_W  = 3;
  localparam int ADDR_W = GRP_W + REG_W;
  localparam int N_GRP  = 3;

  typedef enum logic [REG_W-1:0] {
    RS_CAUSE  = 3'd0,
    RS_SET    = 3'd1,
    RS_MSET   = 3'd2,
    RS_MCLR   = 3'd3,
    RS_MASK   = 3'd4,
    RS_MASKED = 3'd5,
    RS_MODE   = 3'd6,
    RS_NONE   = 3'd7
  } reg_sel_e;

  localparam logic [GRP_W-1:0] GS_SUMM  = 3'd3;
  localparam logic [REG_W-1:0] SR_SUMM  = 3'd0;
  localparam logic [REG_W-1:0] SR_SMASK = 3'd1;
endpackage

// File: rtl/icb_group.sv
module icb_group
  import icb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              acc_i,
  input  logic              we_i,
  input  reg_sel_e          reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cause_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] mode_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] cause_q, mask_q, mode_q;
  logic [DATA_W-1:0] clr, set;
  logic wr, rd;

  assign wr = acc_i && we_i;
  assign rd = acc_i && !we_i;

  always_comb begin
    clr = '0;
    set = '0;
    if (wr && reg_i == RS_CAUSE) clr = wdata_i & ~mode_q;
    if (rd && reg_i == RS_CAUSE) clr = mode_q;
    if (wr && reg_i == RS_SET)   set = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      // events win over clears
      cause_q <= evt_i | set | (cause_q & ~clr);
      if (wr && reg_i == RS_MSET) mask_q <= mask_q | wdata_i;
      if (wr && reg_i == RS_MCLR) mask_q <= mask_q & ~wdata_i;
      if (wr && reg_i == RS_MODE) mode_q <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign pend_o  = |(cause_q & ~mask_q);
endmodule

// File: rtl/icb_summary.sv
module icb_summary
  import icb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_GRP-1:0]  pend_i,
  input  logic              rd_clr_i,
  input  logic              smask_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_GRP-1:0]  summ_o,
  output logic [DATA_W-1:0] smask_o,
  output logic              irq_o
);
  logic [N_GRP-1:0]  summ_q;
  logic [DATA_W-1:0] smask_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      summ_q  <= '0;
      smask_q <= '1;
      irq_q   <= 1'b0;
    end else begin
      summ_q <= pend_i | (summ_q & ~{N_GRP{rd_clr_i}});
      if (smask_wr_i) smask_q <= wdata_i;
      irq_q <= |(summ_q & ~smask_q[N_GRP-1:0]);
    end
  end

  assign summ_o  = summ_q;
  assign smask_o = smask_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import icb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] tx_evt_i,
  input  logic [DATA_W-1:0] rx_evt_i,
  input  logic [DATA_W-1:0] misc_evt_i,
  output logic              irq_o
);
  logic [N_GRP-1:0][DATA_W-1:0] evt_v, cause_v, mask_v, mode_v;
  logic [N_GRP-1:0]             pend_v, summ_v;
  logic [DATA_W-1:0]            smask_v;
  logic [GRP_W-1:0]             grp;
  reg_sel_e                     rsel;
  logic [DATA_W-1:0]            rdata_d, rdata_q;
  logic                         summ_rd, smask_wr;

  assign evt_v[0] = tx_evt_i;
  assign evt_v[1] = rx_evt_i;
  assign evt_v[2] = misc_evt_i;

  assign grp  = addr_i[ADDR_W-1:REG_W];
  assign rsel = reg_sel_e'(addr_i[REG_W-1:0]);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    icb_group #(.DATA_W(DATA_W)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_v[g]),
      .acc_i   (req_i && grp == GRP_W'(g)),
      .we_i    (we_i),
      .reg_i   (rsel),
      .wdata_i (wdata_i),
      .cause_o (cause_v[g]),
      .mask_o  (mask_v[g]),
      .mode_o  (mode_v[g]),
      .pend_o  (pend_v[g])
    );
  end

  assign summ_rd  = req_i && !we_i && grp == GS_SUMM && addr_i[REG_W-1:0] == SR_SUMM;
  assign smask_wr = req_i && we_i && grp == GS_SUMM && addr_i[REG_W-1:0] == SR_SMASK;

  icb_summary #(.DATA_W(DATA_W)) u_summ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend_v),
    .rd_clr_i   (summ_rd),
    .smask_wr_i (smask_wr),
    .wdata_i    (wdata_i),
    .summ_o     (summ_v),
    .smask_o    (smask_v),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_d = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (grp == GRP_W'(g)) begin
        case (rsel)
          RS_CAUSE:  rdata_d = cause_v[g];
          RS_MASK:   rdata_d = mask_v[g];
          RS_MASKED: rdata_d = cause_v[g] & ~mask_v[g];
          RS_MODE:   rdata_d = mode_v[g];
          default:   rdata_d = '0;
        endcase
      end
    end
    if (grp == GS_SUMM) begin
      if (addr_i[REG_W-1:0] == SR_SUMM)  rdata_d = DATA_W'(summ_v);
      if (addr_i[REG_W-1:0] == SR_SMASK) rdata_d = smask_v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_q <= '0;
    else if (req_i && !we_i)     rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk
  import icb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_i,
  input logic                         we_i,
  input logic [DATA_W-1:0]            tx_evt_i,
  input logic [N_GRP-1:0][DATA_W-1:0] cause_v,
  input logic [N_GRP-1:0][DATA_W-1:0] mask_v,
  input logic [N_GRP-1:0]             summ_v,
  input logic [DATA_W-1:0]            smask_v,
  input logic                         irq_o
);
  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_evt_i != '0) |=> ((cause_v[0] & $past(tx_evt_i)) == $past(tx_evt_i))); // R5

  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && tx_evt_i == '0) |=> $stable(cause_v[0])); // R4

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(mask_v)); // R6

  AST_SUMM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_v[0] & ~mask_v[0]) != '0) |=> summ_v[0]); // R9

  AST_IRQ_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(summ_v) & ~$past(smask_v[N_GRP-1:0])))); // R10
endmodule

bind irq_cause_bank irq_cause_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .tx_evt_i (tx_evt_i),
  .cause_v  (cause_v),
  .mask_v   (mask_v),
  .summ_v   (summ_v),
  .smask_v  (smask_v),
  .irq_o    (irq_o)
);

// File: tb/irq_cause_bank_test.sv
module irq_cause_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] tx_evt = '0, rx_evt = '0, misc_evt = '0;
  logic        irq;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_cause_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
    .misc_evt_i(misc_evt), .irq_o(irq)
  );

  function automatic logic [5:0] a(input int g, input int r);
    return 6'((g << 3) | r);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] ad, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = ad; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] ad, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = ad;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic pulse(input int g, input logic [31:0] v);
    @(negedge clk);
    case (g) 0: tx_evt = v; 1: rx_evt = v; default: misc_evt = v; endcase
    @(negedge clk); tx_evt = '0; rx_evt = '0; misc_evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(a(0,0), d); chk("R1 tx cause", d, 32'h0);
    rd(a(0,4), d); chk("R1 tx mask", d, 32'hFFFF_FFFF);
    rd(a(2,6), d); chk("R1 misc mode", d, 32'h0);
    rd(a(3,1), d); chk("R1 summary mask", d, 32'hFFFF_FFFF);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(a(1,7), d); chk("R11 unused addr", d, 32'h0);
  endtask

  task automatic t_latch_w1c;
    logic [31:0] d;
    pulse(0, 32'h5);
    repeat (3) @(negedge clk);
    rd(a(0,0), d); chk("R2 latched", d, 32'h5);
    rd(a(0,0), d); chk("R4 w1c survives read", d, 32'h5);
    wr(a(0,0), 32'h1);
    rd(a(0,0), d); chk("R3 w1c clear", d, 32'h4);
    wr(a(0,0), 32'h0);
    rd(a(0,0), d); chk("R3 zero write no effect", d, 32'h4);
  endtask

  task automatic t_cor;
    logic [31:0] d;
    wr(a(1,6), 32'hFFFF_FFFF);
    pulse(1, 32'h30);
    rd(a(1,0), d); chk("R4 cor read value", d, 32'h30);
    rd(a(1,0), d); chk("R4 cor cleared", d, 32'h0);
    wr(a(2,6), 32'hF7FF_FFFF);
    pulse(2, 32'h0800_0001);
    rd(a(2,0), d); chk("R4 misc mixed read", d, 32'h0800_0001);
    rd(a(2,0), d); chk("R4 misc bit27 survives", d, 32'h0800_0000);
    wr(a(2,0), 32'h0800_0000);
    rd(a(2,0), d); chk("R3 misc bit27 w1c", d, 32'h0);
    pulse(1, 32'h1);
    wr(a(1,0), 32'h1);
    rd(a(1,0), d); chk("R3 cor bit ignores write", d, 32'h1);
    rd(a(1,0), d); chk("R4 rx clear after read", d, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk); req = 1; we = 1; addr = a(0,0); wdata = 32'h4; tx_evt = 32'h4;
    @(negedge clk); req = 0; we = 0; wdata = '0; tx_evt = '0;
    rd(a(0,0), d); chk("R5 event beats w1c", d, 32'h4);
    wr(a(1,6), 32'h2);
    @(negedge clk); req = 1; we = 0; addr = a(1,0); rx_evt = 32'h2;
    @(negedge clk); req = 0; rx_evt = '0;
    rd(a(1,0), d); chk("R5 event beats read clear", d, 32'h2);
    rd(a(1,0), d); chk("R4 rx then cleared", d, 32'h0);
    wr(a(0,0), 32'h4);
    rd(a(0,0), d); chk("R3 tx cleared", d, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(a(0,3), 32'h0000_00F0);
    rd(a(0,4), d); chk("R6 mask clear", d, 32'hFFFF_FF0F);
    wr(a(0,2), 32'h10);
    rd(a(0,4), d); chk("R6 mask set", d, 32'hFFFF_FF1F);
    wr(a(0,2), 32'h0);
    rd(a(0,4), d); chk("R6 zero write keeps mask", d, 32'hFFFF_FF1F);
    wr(a(0,1), 32'h60);
    rd(a(0,0), d); chk("R8 software set", d, 32'h60);
    rd(a(0,5), d); chk("R7 masked view", d, 32'h60);
    wr(a(0,2), 32'h20);
    rd(a(0,5), d); chk("R7 masked view after mask", d, 32'h40);
    rd(a(0,0), d); chk("R7 masked read clears nothing", d, 32'h60);
  endtask

  task automatic t_summary;
    logic [31:0] d;
    rd(a(3,0), d); chk("R9 tx summary", d, 32'h1);
    rd(a(3,0), d); chk("R9 pending re-sets", d, 32'h1);
    repeat (2) @(negedge clk);
    chk("R10 irq masked", {31'h0, irq}, 32'h0);
    wr(a(3,1), 32'hFFFF_FFF8);
    repeat (2) @(negedge clk);
    chk("R10 irq raised", {31'h0, irq}, 32'h1);
    wr(a(0,0), 32'h60);
    repeat (2) @(negedge clk);
    chk("R9 summary stays latched", {31'h0, irq}, 32'h1);
    rd(a(3,0), d); chk("R9 latched value", d, 32'h1);
    rd(a(3,0), d); chk("R9 clear on read", d, 32'h0);
    repeat (2) @(negedge clk);
    chk("R10 irq dropped", {31'h0, irq}, 32'h0);
    wr(a(2,1), 32'h8);
    wr(a(2,3), 32'h8);
    repeat (2) @(negedge clk);
    chk("R10 irq misc", {31'h0, irq}, 32'h1);
    rd(a(3,0), d); chk("R9 misc bit2", d, 32'h4);
    wr(a(3,1), 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    chk("R10 summary mask all", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_w1c();
    t_cor();
    t_collide();
    t_mask();
    t_summary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule